// File: doc/BRIEF.md
# Cartridge Transfer Sequencer

This block runs one transfer on a cartridge bus. A host write to the control word starts it, provided the start bit is set and no transfer is under way. At that moment the 8-byte command is captured from the command inputs, together with the word count and the direction. The sequencer then waits out a start delay and moves 32-bit words between the host and a card-side data port. When the last word has gone through, it drops busy. If the interrupt enable is set, it also pulses a completion interrupt.

The delay is a fixed base of 8 cycles. The low 13 bits of the control word are added to it, but only for a read transfer. A write transfer always uses the base delay alone. Words pass through a one-word slot. In a read, the card fills the slot and the host drains it. In a write, the host fills the slot and the card drains it.

The controller has three states. `ST_IDLE` waits for a start. The transition "start accepted" leads to `ST_WAIT`, which counts the delay. From there, "delay over, zero words" returns to `ST_IDLE`, and "delay over, words pending" leads to `ST_MOVE`. `ST_MOVE` moves data, and "last word taken" returns it to `ST_IDLE`.

Top module: `cart_xfer_seq`

## Requirements
- R1: After synchronous reset, busy_o, irq_o, data_ready_o, card_rready_o, card_wvalid_o and host_wready_o are all 0.
- R2: A control write with bit 31 set while idle is accepted. From the next cycle busy_o is 1 and cmd_o holds the cmd_i value present at the write.
- R3: With bit 30 clear (read), a zero-word transfer keeps busy_o high for exactly 8 + ctrl[12:0] cycles.
- R4: With bit 30 set (write), a zero-word transfer keeps busy_o high for exactly 8 cycles, whatever ctrl[12:0] holds.
- R5: dir_o shows the bit 30 value captured at the accepted start: 0 = card to host (read), 1 = host to card (write). It is 0 after reset.
- R6: In a read, every word accepted from the card port reaches host_rdata_o in order. data_ready_o is high while a word waits, and card_rready_o stays low until the host pops that word with host_pop_i.
- R7: In a write, every word pushed by the host reaches card_wdata_o in order, with card_wvalid_o high until card_wready_i takes it.
- R8: A transfer with len_i = 0 moves no data and completes when the delay ends.
- R9: busy_o falls in the cycle after the last word is handed over.
- R10: On completion, irq_o is a single-cycle pulse when irq_en_i is 1 in the completing cycle. Otherwise irq_o stays 0.
- R11: A start write that arrives while busy_o is 1 is ignored: cmd_o and the busy duration are unchanged.
- R12: A control write with bit 31 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word: [31] start, [30] write direction, [12:0] extra read delay |
| cmd_i | input | 64 | 8-byte command from the command registers |
| len_i | input | LEN_W | Number of 32-bit words to move |
| irq_en_i | input | 1 | Completion interrupt enable |
| busy_o | output | 1 | Transfer in progress |
| dir_o | output | 1 | Captured direction, 1 = write |
| cmd_o | output | 64 | Captured command |
| irq_o | output | 1 | Completion pulse |
| host_rdata_o | output | DATA_W | Read word for the host |
| data_ready_o | output | 1 | A read word is waiting |
| host_pop_i | input | 1 | Host takes the waiting word |
| host_wdata_i | input | DATA_W | Write word from the host |
| host_wvalid_i | input | 1 | Host write word valid |
| host_wready_o | output | 1 | Slot can accept a host word |
| card_rdata_i | input | DATA_W | Word from the card |
| card_rvalid_i | input | 1 | Card word valid |
| card_rready_o | output | 1 | Slot can accept a card word |
| card_wdata_o | output | DATA_W | Word to the card |
| card_wvalid_o | output | 1 | Word to the card valid |
| card_wready_i | input | 1 | Card takes the word |

## Verification
Zero-word starts are tried with the extra-delay field at zero and at a non-zero value, in both directions. This shows whether the field is added only for reads. Data runs are tried in both directions, once against a host or card that always accepts and once against one that stalls every other cycle. The stalling case separates correct slot back-pressure from dropped or repeated words. A second start issued during a transfer, a write with the start bit clear, and completion with the interrupt disabled cover the ignore and gating rules.

// File: rtl/cart_xfer_pkg.sv
package cart_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MOVE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/cart_xfer_delay.sv
module cart_xfer_delay #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             tick_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = tick_i && (cnt_q == CNT_W'(1));

    // R3: a loaded delay is never empty
    p_load_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q != '0));
endmodule

// File: rtl/cart_xfer_slot.sv
module cart_xfer_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         take_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);
    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (load_i) begin
            full_q <= 1'b1;
            data_q <= data_i;
        end else if (take_i) begin
            full_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

    // R6: a held word is never overwritten
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst)
        full_q && !take_i |-> !load_i);
    // R6: a word is taken only when present
    p_take_full_r6: assert property (@(posedge clk) disable iff (rst)
        take_i |-> full_q);
endmodule

// File: rtl/cart_xfer_seq.sv
module cart_xfer_seq
    import cart_xfer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CMD_W    = 64,
    parameter int LEN_W    = 8,
    parameter int DLY_W    = 13,
    parameter int BASE_DLY = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we_i,
    input  logic [31:0]       ctrl_wdata_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              irq_en_i,
    output logic              busy_o,
    output logic              dir_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              data_ready_o,
    input  logic              host_pop_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              host_wvalid_i,
    output logic              host_wready_o,
    input  logic [DATA_W-1:0] card_rdata_i,
    input  logic              card_rvalid_i,
    output logic              card_rready_o,
    output logic [DATA_W-1:0] card_wdata_o,
    output logic              card_wvalid_o,
    input  logic              card_wready_i
);
    localparam int CNT_W     = DLY_W + 1;
    localparam int START_BIT = 31;
    localparam int WDIR_BIT  = 30;

    xfer_state_t        state_q, state_d;
    logic               dir_q;
    logic [CMD_W-1:0]   cmd_q;
    logic [LEN_W-1:0]   words_q;
    logic               irq_q;
    logic               accept, dly_last, moving, finish;
    logic               slot_full, slot_load, slot_take;
    logic [CNT_W-1:0]   dly_val;
    logic [DATA_W-1:0]  slot_din, slot_dout;

    assign accept  = ctrl_we_i && ctrl_wdata_i[START_BIT] && (state_q == ST_IDLE);
    assign dly_val = CNT_W'(BASE_DLY) +
                     (ctrl_wdata_i[WDIR_BIT] ? CNT_W'(0) : CNT_W'(ctrl_wdata_i[DLY_W-1:0]));

    cart_xfer_delay #(.CNT_W(CNT_W)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .val_i  (dly_val),
        .tick_i (state_q == ST_WAIT),
        .last_o (dly_last)
    );

    cart_xfer_slot #(.W(DATA_W)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .load_i (slot_load),
        .data_i (slot_din),
        .take_i (slot_take),
        .full_o (slot_full),
        .data_o (slot_dout)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign finish = ((state_q == ST_WAIT) && dly_last && (words_q == '0)) ||
                    (moving && slot_take && (words_q == LEN_W'(1)));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_WAIT;
            ST_WAIT: if (dly_last) state_d = (words_q == '0) ? ST_IDLE : ST_MOVE;
            ST_MOVE: if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // captured transfer context
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= 1'b0;
            cmd_q   <= '0;
            words_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= finish && irq_en_i;
            if (accept) begin
                dir_q   <= ctrl_wdata_i[WDIR_BIT];
                cmd_q   <= cmd_i;
                words_q <= len_i;
            end else if (slot_take) begin
                words_q <= words_q - 1'b1;
            end
        end
    end

    // outputs
    assign moving        = (state_q == ST_MOVE);
    assign busy_o        = (state_q != ST_IDLE);
    assign dir_o         = dir_q;
    assign cmd_o         = cmd_q;
    assign irq_o         = irq_q;
    assign card_rready_o = moving && !dir_q && !slot_full;
    assign data_ready_o  = moving && !dir_q && slot_full;
    assign host_wready_o = moving && dir_q && !slot_full;
    assign card_wvalid_o = moving && dir_q && slot_full;
    assign host_rdata_o  = slot_dout;
    assign card_wdata_o  = slot_dout;
    assign slot_din      = dir_q ? host_wdata_i : card_rdata_i;
    assign slot_load     = dir_q ? (host_wvalid_i && host_wready_o)
                                 : (card_rvalid_i && card_rready_o);
    assign slot_take     = dir_q ? (card_wvalid_o && card_wready_i)
                                 : (data_ready_o && host_pop_i);

    // R2: accepted start raises busy and captures the command
    p_start_capture_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o && (cmd_o == $past(cmd_i)));
    // R11: command stays put during a transfer
    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(cmd_o));
    // R10: interrupt is one cycle wide
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);
    // R10: interrupt only when enabled at completion
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(irq_en_i));
    // R9: end of busy coincides with gated interrupt
    p_busy_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (irq_o == $past(irq_en_i)));
    // R6: card is held off while a word waits for the host
    p_ready_block_r6: assert property (@(posedge clk) disable iff (rst)
        data_ready_o |-> !card_rready_o);
    // R1: no data handshake outside a transfer
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !card_rready_o && !card_wvalid_o && !host_wready_o && !data_ready_o);
endmodule

// File: tb/cart_xfer_seq_bench.sv
module cart_xfer_seq_bench;
    localparam int LEN_W = 8;
    localparam logic [31:0] STEP = 32'h0101_0103;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we_i = 1'b0;
    logic [31:0] ctrl_wdata_i = '0;
    logic [63:0] cmd_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic        irq_en_i = 1'b0;
    logic        busy_o, dir_o, irq_o, data_ready_o, host_wready_o, card_rready_o, card_wvalid_o;
    logic [63:0] cmd_o;
    logic [31:0] host_rdata_o, card_wdata_o;
    logic        host_pop_i = 1'b0, host_wvalid_i = 1'b0, card_rvalid_i = 1'b0, card_wready_i = 1'b0;
    logic [31:0] host_wdata_i = '0, card_rdata_i = '0;

    int errs = 0, checks = 0;
    int busy_cnt = 0, irq_cnt = 0, cyc = 0;
    logic [31:0] exp_q[$];
    logic [31:0] rseed = '0, wseed = '0;
    int ridx = 0, widx = 0;
    bit stall = 1'b0, rd_on = 1'b0, wr_on = 1'b0;

    always #10 clk = ~clk;

    cart_xfer_seq u_cart_xfer_seq (
        .clk(clk), .rst(rst), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
        .cmd_i(cmd_i), .len_i(len_i), .irq_en_i(irq_en_i), .busy_o(busy_o),
        .dir_o(dir_o), .cmd_o(cmd_o), .irq_o(irq_o), .host_rdata_o(host_rdata_o),
        .data_ready_o(data_ready_o), .host_pop_i(host_pop_i), .host_wdata_i(host_wdata_i),
        .host_wvalid_i(host_wvalid_i), .host_wready_o(host_wready_o),
        .card_rdata_i(card_rdata_i), .card_rvalid_i(card_rvalid_i),
        .card_rready_o(card_rready_o), .card_wdata_o(card_wdata_o),
        .card_wvalid_o(card_wvalid_o), .card_wready_i(card_wready_i)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // counters and stimulus models: sample at negedge, drive at posedge+2
    always @(negedge clk) begin
        if (busy_o) busy_cnt++;
        if (irq_o) irq_cnt++;
    end

    always begin
        bit rfire, wfire;
        @(negedge clk);
        rfire = card_rvalid_i && card_rready_o;
        wfire = host_wvalid_i && host_wready_o;
        @(posedge clk); #2;
        cyc++;
        if (rfire) ridx++;
        if (wfire) widx++;
        card_rvalid_i = rd_on;
        card_rdata_i  = rseed + STEP * ridx;
        host_pop_i    = rd_on && (!stall || cyc[0]);
        host_wvalid_i = wr_on;
        host_wdata_i  = wseed + STEP * widx;
        card_wready_i = wr_on && (!stall || cyc[0]);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (data_ready_o && host_pop_i) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 extra word", host_rdata_o, 0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(host_rdata_o == e, "R6 read word", host_rdata_o, e);
            end
        end
        if (card_wvalid_o && card_wready_i) begin
            if (exp_q.size() == 0) chk(1'b0, "R7 extra word", card_wdata_o, 0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(card_wdata_o == e, "R7 write word", card_wdata_o, e);
            end
        end
    end

    task automatic start(input logic [31:0] ctrl, input logic [63:0] cmd,
                         input int len, input bit clr);
        @(posedge clk); #2;
        if (clr) begin busy_cnt = 0; irq_cnt = 0; end
        ctrl_we_i = 1'b1; ctrl_wdata_i = ctrl; cmd_i = cmd; len_i = LEN_W'(len);
        @(posedge clk); #2;
        ctrl_we_i = 1'b0; cmd_i = ~cmd;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy_o) return;
        end
        chk(1'b0, "R9 busy never fell", 1, 0);
    endtask

    task automatic push_exp(input logic [31:0] seed, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(seed + STEP * k);
    endtask

    task automatic data_run(input bit wr, input int n, input bit stl, input logic [31:0] seed);
        stall = stl;
        ridx = 0; widx = 0;
        if (wr) wseed = seed; else rseed = seed;
        push_exp(seed, n);
        rd_on = !wr; wr_on = wr;
        irq_en_i = 1'b1;
        start({1'b1, wr, 30'd5}, {seed, ~seed}, n, 1'b1);
        @(negedge clk);
        chk(dir_o == wr, "R5 direction", dir_o, wr);
        chk(cmd_o == {seed, ~seed}, "R2 command captured", cmd_o, {seed, ~seed});
        wait_idle();
        chk(irq_o == 1'b1, "R9 irq with busy fall", irq_o, 1);
        chk(exp_q.size() == 0, wr ? "R7 all words" : "R6 all words", exp_q.size(), 0);
        rd_on = 1'b0; wr_on = 1'b0;
        repeat (3) @(negedge clk);
        chk(irq_cnt == 1, "R10 single pulse", irq_cnt, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !irq_o && !data_ready_o, "R1 reset outputs", {busy_o, irq_o, data_ready_o}, 0);
        chk(!card_rready_o && !card_wvalid_o && !host_wready_o, "R1 reset handshakes",
            {card_rready_o, card_wvalid_o, host_wready_o}, 0);
        chk(dir_o == 1'b0, "R5 reset direction", dir_o, 0);

        // R3 R8 R10: read, no extra delay, irq enabled
        irq_en_i = 1'b1;
        start({1'b1, 1'b0, 30'd0}, 64'h11, 0, 1'b1);
        wait_idle();
        chk(busy_cnt == 8, "R3 base delay", busy_cnt, 8);
        chk(irq_o == 1'b1, "R8 zero length completes", irq_o, 1);
        @(negedge clk);
        chk(irq_cnt == 1, "R10 pulse width", irq_cnt, 1);

        // R3 R10: read, extra 25, irq disabled
        irq_en_i = 1'b0;
        start({1'b1, 1'b0, 17'd0, 13'd25}, 64'h22, 0, 1'b1);
        wait_idle();
        chk(busy_cnt == 33, "R3 added delay", busy_cnt, 33);
        repeat (2) @(negedge clk);
        chk(irq_cnt == 0, "R10 disabled irq", irq_cnt, 0);

        // R4 R5: write, low bits ignored
        irq_en_i = 1'b1;
        start({1'b1, 1'b1, 17'd0, 13'd25}, 64'h33, 0, 1'b1);
        @(negedge clk);
        chk(dir_o == 1'b1, "R5 write direction", dir_o, 1);
        wait_idle();
        chk(busy_cnt == 8, "R4 write delay", busy_cnt, 8);

        // R6 R7 R9 data runs
        data_run(1'b0, 4, 1'b0, 32'hA000_0001);
        data_run(1'b0, 5, 1'b1, 32'hB100_0010);
        data_run(1'b1, 4, 1'b0, 32'hC200_0100);
        data_run(1'b1, 6, 1'b1, 32'hD300_1000);
        data_run(1'b0, 1, 1'b0, 32'hE400_0003);

        // R11: start during busy ignored
        start({1'b1, 1'b0, 17'd0, 13'd100}, 64'hAAAA_5555, 0, 1'b1);
        repeat (20) @(negedge clk);
        start({1'b1, 1'b1, 30'd0}, 64'h1234, 0, 1'b0);
        wait_idle();
        chk(busy_cnt == 108, "R11 busy duration kept", busy_cnt, 108);
        chk(cmd_o == 64'hAAAA_5555, "R11 command kept", cmd_o, 64'hAAAA_5555);
        chk(dir_o == 1'b0, "R11 direction kept", dir_o, 0);

        // R12: start bit clear
        start({1'b0, 1'b0, 30'd0}, 64'h77, 0, 1'b1);
        repeat (4) @(negedge clk);
        chk(busy_cnt == 0 && !busy_o, "R12 no start", busy_cnt, 0);
        chk(cmd_o == 64'hAAAA_5555, "R12 command untouched", cmd_o, 64'hAAAA_5555);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule